// File: doc/BRIEF.md
# Two-Identity I2C Target Controller

This block is a byte-level I2C target that listens on a two-wire bus and answers to either of two separately programmed 7-bit addresses, named identity A and identity B. Each identity can be switched on or off by itself and owns a configuration register, a receive holding register and a transmit holding register. All of these sit behind a small synchronous CPU register port.

The block resamples SCL and SDA into the system clock domain and detects START and STOP conditions. It compares the first byte after START with every enabled identity and acknowledges when one of them matches. It then collects written bytes into the matching identity's receive register, or shifts that identity's transmit register onto the bus for a master read. SDA is open-drain: the only bus output is a pull-low enable. Software polls four status flags: receive-full and transmit-empty for each identity.

Top module: `i2c_dual_target`

## Requirements
- R1: After reset both configuration registers, both receive registers and both transmit registers read 0x00. Both receive-full flags are 0, both transmit-empty flags are 1, and `sda_pull_o` is 0.
- R2: A START is SDA falling while SCL is high. It clears any transfer in progress and releases SDA. The next 8 bits, MSB first, form a 7-bit address followed by a direction bit (1 = master reads). When the address matches an enabled identity, SDA is pulled low through the 9th SCL clock.
- R3: When the address byte matches no enabled identity, including an identity whose enable bit is 0, SDA is never pulled for the rest of that transfer, up to the next START.
- R4: In a master write, every data byte is acknowledged in its 9th clock and stored in the selected identity's receive register. The other identity's receive register keeps its value.
- R5: In a master read, the selected identity's transmit register is shifted MSB first, with a new bit put out after each SCL falling edge. A 0 bit pulls SDA low; a 1 bit leaves it released. The same register is sent again for each further byte the master acknowledges.
- R6: If both identities are enabled with the same address, identity A is selected for both writes and reads.
- R7: An identity's receive-full flag is set when a byte is stored in its receive register. It is cleared when the CPU reads that register.
- R8: An identity's transmit-empty flag is cleared by a CPU write to its transmit register. It is set once all 8 bits of that register have been shifted out.
- R9: When the master answers a read byte with NACK (SDA high in the 9th clock), the target releases SDA for the rest of that transfer. A STOP (SDA rising while SCL is high) also releases SDA and ends the transfer.
- R10: CPU map (3-bit offset): 0 = A config, 1 = A transmit, 2 = A receive, 3 = B config, 4 = B transmit, 5 = B receive, 6 = status. In each config register, bit 7 is the enable and bits 6:0 are the address. Status bits are [0] A receive-full, [1] A transmit-empty, [2] B receive-full, [3] B transmit-empty, and bits 7:4 read 0. Config and transmit registers read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| cpu_we | input | 1 | CPU write strobe |
| cpu_re | input | 1 | CPU read strobe (clears receive-full on a receive-register read) |
| cpu_addr | input | 3 | CPU register offset |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational from `cpu_addr` |

## Verification
The assertions assume that the bus master holds SCL in each phase for several system clocks, so that every edge passes the two-flop resampler before the next edge arrives. They also assume that the CPU does not rewrite a configuration register in the same cycle that an address byte is being decoded. The bench's master model holds every SCL quarter-phase for ten system clocks. It changes SDA only in the middle of the SCL low phase, except when it deliberately creates START and STOP. It also writes configuration only between bus transfers. As a result, the priority check and the acknowledge checks always see settled inputs.

// File: rtl/i2c_dual_pkg.sv
package i2c_dual_pkg;

  localparam int NUM_ID   = 2;
  localparam int BYTE_W   = 8;
  localparam int CPU_AW   = 3;
  localparam int KIND_CFG = 0;
  localparam int KIND_TX  = 1;
  localparam int KIND_RX  = 2;
  localparam int REGS_PER_ID = 3;
  localparam logic [CPU_AW-1:0] OFF_STATUS = CPU_AW'(NUM_ID * REGS_PER_ID);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BITS,
    ST_WR_ACK,
    ST_RD_BITS,
    ST_RD_ACK
  } tgt_state_e;

  // register offset of a given identity and register kind
  function automatic logic [CPU_AW-1:0] reg_off(input int id, input int kind);
    return CPU_AW'(id * REGS_PER_ID + kind);
  endfunction

  // {hit, id}: identity A wins when both match
  function automatic logic [1:0] pick_id(input logic [6:0] adr,
                                         input logic [7:0] cfg_a,
                                         input logic [7:0] cfg_b);
    if (cfg_a[7] && (cfg_a[6:0] == adr)) return 2'b10;
    if (cfg_b[7] && (cfg_b[6:0] == adr)) return 2'b11;
    return 2'b00;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_id_regs.sv
module i2c_id_regs
  import i2c_dual_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              tx_we,
  input  logic              rx_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rx_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              tx_done,
  output logic [BYTE_W-1:0] cfg_q,
  output logic [BYTE_W-1:0] tx_q,
  output logic [BYTE_W-1:0] rx_q,
  output logic              rx_full,
  output logic              tx_empty
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      rx_full  <= 1'b0;
      tx_empty <= 1'b1;
    end else begin
      if (cfg_we) cfg_q <= wdata;
      if (tx_we)  tx_q  <= wdata;
      if (rx_done) rx_q <= rx_byte;
      if (rx_done)    rx_full <= 1'b1;
      else if (rx_rd) rx_full <= 1'b0;
      if (tx_we)        tx_empty <= 1'b0;
      else if (tx_done) tx_empty <= 1'b1;
    end
  end

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_dual_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [BYTE_W-1:0] cfg_a,
  input  logic [BYTE_W-1:0] cfg_b,
  input  logic [BYTE_W-1:0] tx_sel,
  output logic              sda_pull,
  output logic              act_id,
  output logic              ev_match,
  output logic              ev_rx_done,
  output logic              ev_tx_done,
  output logic              engaged,
  output logic [BYTE_W-1:0] shift_q
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  tgt_state_e        st;
  logic [CNT_W-1:0]  cnt;
  logic              rd_dir;
  logic              nack_q;
  logic [1:0]        pick;

  assign pick = pick_id(shift_q[7:1], cfg_a, cfg_b);

  assign engaged = (st == ST_ADDR_ACK) || (st == ST_WR_BITS) || (st == ST_WR_ACK) ||
                   (st == ST_RD_BITS) || (st == ST_RD_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      rd_dir     <= 1'b0;
      nack_q     <= 1'b0;
      act_id     <= 1'b0;
      sda_pull   <= 1'b0;
      shift_q    <= '0;
      ev_match   <= 1'b0;
      ev_rx_done <= 1'b0;
      ev_tx_done <= 1'b0;
    end else begin
      ev_match   <= 1'b0;
      ev_rx_done <= 1'b0;
      ev_tx_done <= 1'b0;
      if (bus_start) begin
        st       <= ST_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (bus_stop) begin
        st       <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              shift_q <= {shift_q[BYTE_W-2:0], sda_s};
              cnt     <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              if (pick[1]) begin
                st       <= ST_ADDR_ACK;
                sda_pull <= 1'b1;
                act_id   <= pick[0];
                rd_dir   <= shift_q[0];
                ev_match <= 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rd_dir) begin
                sda_pull <= ~tx_sel[BYTE_W-1];
                shift_q  <= {tx_sel[BYTE_W-2:0], 1'b0};
                cnt      <= CNT_W'(1);
                st       <= ST_RD_BITS;
              end else begin
                sda_pull <= 1'b0;
                cnt      <= '0;
                st       <= ST_WR_BITS;
              end
            end
          end
          ST_WR_BITS: begin
            if (scl_rise) begin
              shift_q <= {shift_q[BYTE_W-2:0], sda_s};
              cnt     <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              ev_rx_done <= 1'b1;
              sda_pull   <= 1'b1;
              st         <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              cnt      <= '0;
              st       <= ST_WR_BITS;
            end
          end
          ST_RD_BITS: begin
            if (scl_fall) begin
              if (cnt == LAST) begin
                sda_pull   <= 1'b0;
                ev_tx_done <= 1'b1;
                st         <= ST_RD_ACK;
              end else begin
                sda_pull <= ~shift_q[BYTE_W-1];
                shift_q  <= {shift_q[BYTE_W-2:0], 1'b0};
                cnt      <= cnt + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              if (nack_q) begin
                st <= ST_IDLE;
              end else begin
                sda_pull <= ~tx_sel[BYTE_W-1];
                shift_q  <= {tx_sel[BYTE_W-2:0], 1'b0};
                cnt      <= CNT_W'(1);
                st       <= ST_RD_BITS;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_dual_target.sv
module i2c_dual_target
  import i2c_dual_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              cpu_we,
  input  logic              cpu_re,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [BYTE_W-1:0] cpu_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, ev_start, ev_stop;
  logic act_id, ev_match, ev_rx_done, ev_tx_done, engaged;
  logic [BYTE_W-1:0] shift_q, tx_sel;
  logic [NUM_ID-1:0][BYTE_W-1:0] cfg_v, tx_v, rx_v;
  logic [NUM_ID-1:0] rxf_v, txe_v;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(ev_start), .bus_stop(ev_stop)
  );

  assign tx_sel = tx_v[act_id];

  i2c_target_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(ev_start), .bus_stop(ev_stop),
    .cfg_a(cfg_v[0]), .cfg_b(cfg_v[1]), .tx_sel(tx_sel),
    .sda_pull(sda_pull_o), .act_id(act_id), .ev_match(ev_match),
    .ev_rx_done(ev_rx_done), .ev_tx_done(ev_tx_done), .engaged(engaged),
    .shift_q(shift_q)
  );

  generate
    for (genvar g = 0; g < NUM_ID; g++) begin : g_id
      logic is_act;
      assign is_act = (act_id == 1'(g));
      i2c_id_regs regs_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cpu_we && cpu_addr == reg_off(g, KIND_CFG)),
        .tx_we(cpu_we && cpu_addr == reg_off(g, KIND_TX)),
        .rx_rd(cpu_re && cpu_addr == reg_off(g, KIND_RX)),
        .wdata(cpu_wdata),
        .rx_done(ev_rx_done && is_act),
        .rx_byte(shift_q),
        .tx_done(ev_tx_done && is_act),
        .cfg_q(cfg_v[g]), .tx_q(tx_v[g]), .rx_q(rx_v[g]),
        .rx_full(rxf_v[g]), .tx_empty(txe_v[g])
      );
    end
  endgenerate

  always_comb begin
    cpu_rdata = '0;
    for (int i = 0; i < NUM_ID; i++) begin
      if (cpu_addr == reg_off(i, KIND_CFG)) cpu_rdata = cfg_v[i];
      if (cpu_addr == reg_off(i, KIND_TX))  cpu_rdata = tx_v[i];
      if (cpu_addr == reg_off(i, KIND_RX))  cpu_rdata = rx_v[i];
    end
    if (cpu_addr == OFF_STATUS) cpu_rdata = {4'b0, txe_v[1], rxf_v[1], txe_v[0], rxf_v[0]};
  end

endmodule

// File: rtl/i2c_dual_target_chk.sv
module i2c_dual_target_chk
  import i2c_dual_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic sda_pull_o,
  input logic cpu_we,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic ev_start,
  input logic ev_stop,
  input logic ev_match,
  input logic ev_rx_done,
  input logic ev_tx_done,
  input logic act_id,
  input logic engaged,
  input logic [BYTE_W-1:0] shift_q,
  input logic [NUM_ID-1:0][BYTE_W-1:0] cfg_v,
  input logic [NUM_ID-1:0][BYTE_W-1:0] rx_v,
  input logic [NUM_ID-1:0] rxf_v,
  input logic [NUM_ID-1:0] txe_v
);
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_pull_o); // R2
  AST_ACK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_match |-> sda_pull_o); // R2
  AST_QUIET_UNLESS_ENGAGED: assert property (@(posedge clk) disable iff (!rst_n)
    !engaged |-> !sda_pull_o); // R3
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_rx_done |=> $stable(rx_v)); // R4
  AST_PRIORITY_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_match && cfg_v[0][7] && cfg_v[0][6:0] == shift_q[7:1]) |-> !act_id); // R6
  AST_RXF_SET_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_done && !act_id) |=> rxf_v[0]); // R7
  AST_TXE_SET_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_done && !act_id && !(cpu_we && cpu_addr == reg_off(0, KIND_TX))) |=> txe_v[0]); // R8
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_pull_o); // R9
endmodule

bind i2c_dual_target i2c_dual_target_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sda_pull_o(sda_pull_o), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .ev_start(ev_start), .ev_stop(ev_stop),
  .ev_match(ev_match), .ev_rx_done(ev_rx_done), .ev_tx_done(ev_tx_done),
  .act_id(act_id), .engaged(engaged), .shift_q(shift_q), .cfg_v(cfg_v),
  .rx_v(rx_v), .rxf_v(rxf_v), .txe_v(txe_v)
);

// File: tb/i2c_dual_target_tb_top.sv
module i2c_dual_target_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, sda_line;
  logic cpu_we = 1'b0, cpu_re = 1'b0;
  logic [2:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic done = 1'b0;
  logic watch_en = 1'b0, saw_pull = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  i2c_dual_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  typedef struct { string req; int val; } item_t;
  item_t exp_q[$];
  int    obs_q[$];
  int n_vec = 0, n_miss = 0;

  // driver side: expected then observed
  task automatic chk(input string req, input int expv, input int actv);
    item_t it;
    it.req = req; it.val = expv;
    exp_q.push_back(it);
    obs_q.push_back(actv);
  endtask

  // monitor: pops and compares
  always @(negedge clk) begin
    if (exp_q.size() > 0 && obs_q.size() > 0) begin
      item_t e;
      int o;
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      n_vec++;
      if (o != e.val) begin
        n_miss++;
        $display("FAIL %s actual=%0h expected=%0h", e.req, o, e.val);
      end
    end
  end

  always @(negedge clk) if (watch_en && sda_pull) saw_pull = 1'b1;

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_re = 1'b1;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_re = 1'b0;
  endtask

  task automatic m_start();
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(2*Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b1; wait_q(2*Q);
  endtask

  task automatic m_bit(input logic b);
    sda_m = b; wait_q(Q);
    scl_m = 1'b1; wait_q(2*Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic m_rbit(output logic b);
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    b = sda_line; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) m_bit(d[i]);
    m_rbit(b);
    acked = ~b;
  endtask

  task automatic m_rbyte(input logic send_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      m_rbit(b);
      d[i] = b;
    end
    m_bit(~send_ack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic ak;
    wait_q(5);
    rst_n = 1'b1;
    wait_q(5);

    // R1 reset state, R10 map
    cpu_rd(3'd0, r); chk("R1 cfgA", 8'h00, r);
    cpu_rd(3'd3, r); chk("R1 cfgB", 8'h00, r);
    cpu_rd(3'd2, r); chk("R1 rxA", 8'h00, r);
    cpu_rd(3'd5, r); chk("R1 rxB", 8'h00, r);
    cpu_rd(3'd6, r); chk("R1 status", 8'h0A, r);
    chk("R1 pull", 0, sda_pull);

    cpu_wr(3'd0, 8'hA1);  // A enabled @0x21
    cpu_wr(3'd3, 8'hB5);  // B enabled @0x35
    cpu_rd(3'd0, r); chk("R10 cfgA readback", 8'hA1, r);

    // R2 R4 master write to A
    m_start();
    m_wbyte(8'h42, ak); chk("R2 ack addr A", 1, ak);
    m_wbyte(8'hA5, ak); chk("R4 ack data1", 1, ak);
    m_wbyte(8'h3C, ak); chk("R4 ack data2", 1, ak);
    m_stop();
    cpu_rd(3'd6, r); chk("R7 rxf A set", 8'h0B, r);
    cpu_rd(3'd2, r); chk("R4 rxA last byte", 8'h3C, r);
    cpu_rd(3'd6, r); chk("R7 rxf A cleared", 8'h0A, r);
    cpu_rd(3'd5, r); chk("R4 rxB untouched", 8'h00, r);

    // write to B
    m_start();
    m_wbyte(8'h6A, ak); chk("R2 ack addr B", 1, ak);
    m_wbyte(8'h5A, ak); chk("R4 ack B data", 1, ak);
    m_stop();
    cpu_rd(3'd5, r); chk("R4 rxB", 8'h5A, r);
    cpu_rd(3'd2, r); chk("R4 rxA kept", 8'h3C, r);

    // R3 unmatched address
    saw_pull = 1'b0; watch_en = 1'b1;
    m_start();
    m_wbyte(8'h20, ak); chk("R3 no ack unmatched", 0, ak);
    m_wbyte(8'h00, ak);
    m_stop();
    watch_en = 1'b0;
    chk("R3 never pulled", 0, saw_pull);

    // R3 disabled identity
    cpu_wr(3'd0, 8'h21);
    saw_pull = 1'b0; watch_en = 1'b1;
    m_start();
    m_wbyte(8'h42, ak); chk("R3 no ack disabled", 0, ak);
    m_wbyte(8'hFF, ak);
    m_stop();
    watch_en = 1'b0;
    chk("R3 disabled never pulled", 0, saw_pull);
    cpu_rd(3'd2, r); chk("R3 rxA unchanged", 8'h3C, r);
    cpu_wr(3'd0, 8'hA1);

    // R5 R8 R9 read from A
    cpu_wr(3'd1, 8'hC6);
    cpu_rd(3'd6, r); chk("R8 txe A cleared", 8'h08, r);
    m_start();
    m_wbyte(8'h43, ak); chk("R2 ack read addr", 1, ak);
    m_rbyte(1'b1, r); chk("R5 read A byte1", 8'hC6, r);
    cpu_rd(3'd6, r); chk("R8 txe A set", 8'h0A, r);
    m_rbyte(1'b0, r); chk("R5 read A byte2", 8'hC6, r);
    m_rbyte(1'b0, r); chk("R9 released after nack", 8'hFF, r);
    m_stop();

    // R6 priority, both at 0x21
    cpu_wr(3'd3, 8'hA1);
    m_start();
    m_wbyte(8'h42, ak); chk("R6 ack shared", 1, ak);
    m_wbyte(8'h77, ak);
    m_stop();
    cpu_rd(3'd2, r); chk("R6 write went to A", 8'h77, r);
    cpu_rd(3'd5, r); chk("R6 B not written", 8'h5A, r);
    cpu_wr(3'd1, 8'h81);
    cpu_wr(3'd4, 8'h18);
    m_start();
    m_wbyte(8'h43, ak);
    m_rbyte(1'b0, r); chk("R6 read from A", 8'h81, r);
    m_stop();

    // R5 read from B
    cpu_wr(3'd3, 8'hB5);
    m_start();
    m_wbyte(8'h6B, ak); chk("R2 ack B read", 1, ak);
    m_rbyte(1'b0, r); chk("R5 read B", 8'h18, r);
    m_stop();
    cpu_rd(3'd6, r); chk("R8 txe B set", 8'h0A, r);

    // R2 repeated START aborts a write in progress
    m_start();
    m_wbyte(8'h42, ak);
    for (int i = 0; i < 4; i++) m_bit(1'b1);
    m_start();
    m_wbyte(8'h6A, ak); chk("R2 restart ack", 1, ak);
    m_wbyte(8'h11, ak);
    m_stop();
    cpu_rd(3'd5, r); chk("R2 restart rxB", 8'h11, r);
    cpu_rd(3'd2, r); chk("R2 restart rxA kept", 8'h77, r);
    chk("R9 idle released", 0, sda_pull);

    while (exp_q.size() > 0) @(negedge clk);
    wait_q(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

endmodule